// File: doc/BRIEF.md
# Register-Mapped Power-Chip Access Channel

This block is the front end of a single access channel toward a power-management chip that sits behind a serial link. A host writes one command word that holds a write flag, a halfword address and write data. The block hands that request to an abstract serial back-end engine over a valid/acknowledge handshake. A small state machine follows each request, and the host can see its state in a read-only status word at any time. The serial protocol engine itself is outside this block.

Writes go back to idle as soon as the back end acknowledges them. Reads stop in a hold state in which the returned 16-bit data sits in the status word. They stay there until the host writes the valid-clear register, so the host can collect the result at its own pace. While a request is in flight, new commands are ignored. The status word also carries an init-done flag and the back-end link idle flag, so that software can wait for both before it starts an access.

Top module: `pmic_chan_fsm`

## Requirements
- R1: A command write (`reg_we`=1, `reg_sel`=0) taken in IDLE moves the channel to REQ on the next clock edge. The back-end outputs then carry the command: write flag from bit 31 (1 = write), halfword address from bits 30:16, write data from bits 15:0.
- R2: A command write that arrives in any state other than IDLE is ignored. The state, `be_write_o`, `be_addr_o` and `be_wdata_o` stay unchanged.
- R3: The request-pending status bit (bit 19) and `be_valid_o` are 1 from the edge that accepts a command until the edge that samples `be_ack_i`=1, and 0 otherwise.
- R4: A write request in REQ returns to IDLE on the edge at which `be_ack_i` is 1.
- R5: A read request in REQ moves to WAIT_DATA on the ack edge and captures `be_rdata_i`. On the next edge it moves to WAIT_VLDCLR. From the ack edge on, the captured data shows in status bits 15:0.
- R6: A write to the valid-clear register (`reg_sel`=1) with bit 0 set, made in WAIT_VLDCLR, returns the channel to IDLE. A clear write with bit 0 at 0, or a clear write in any other state, has no effect.
- R7: Status bits 18:16 hold the state, encoded as IDLE=0, REQ=2, WAIT_DATA=4, WAIT_VLDCLR=6. Bit 20 shows `link_idle_i` and bit 21 shows `init_done_i`. Bit 22 (system idle) is 1 when the state is IDLE and the link is idle. Bits 31:23 read 0.
- R8: After reset the state is IDLE, the read-data field is 0, the pending bit is 0 and `be_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 valid-clear |
| reg_wdata | input | 32 | Register write data |
| status_o | output | 32 | Read-only status word |
| init_done_i | input | 1 | Wrapper initialization complete |
| link_idle_i | input | 1 | Back-end serial link idle |
| be_valid_o | output | 1 | Request valid toward back end |
| be_write_o | output | 1 | Request is a write |
| be_addr_o | output | 15 | Halfword address |
| be_wdata_o | output | 16 | Write data |
| be_ack_i | input | 1 | One-cycle acknowledge from back end |
| be_rdata_i | input | 16 | Read data, valid with acknowledge |

## Verification
The command write, the ack and the clear each take effect at the next clock edge. The read path then adds exactly one more edge to get from WAIT_DATA to WAIT_VLDCLR. The bench drives every input at a falling edge and samples one falling edge after the rising edge that should act on it. It checks WAIT_DATA and then WAIT_VLDCLR at two falling edges in a row. Stray commands and clears are driven during a request, and the very next falling edge checks that state and back-end fields are unchanged.

// File: rtl/pmic_chan_pkg.sv
package pmic_chan_pkg;
  localparam int PKG_REG_W  = 32;
  localparam int PKG_DATA_W = 16;
  localparam int STATE_W    = 3;

  typedef enum logic [STATE_W-1:0] {
    CH_IDLE      = 3'd0,
    CH_REQ       = 3'd2,
    CH_WAIT_DATA = 3'd4,
    CH_WAIT_CLR  = 3'd6
  } ch_state_e;
endpackage

// File: rtl/pmic_cmd_hold.sv
module pmic_cmd_hold #(
  parameter int REG_W  = pmic_chan_pkg::PKG_REG_W,
  parameter int DATA_W = pmic_chan_pkg::PKG_DATA_W,
  localparam int ADDR_W = REG_W - 1 - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [REG_W-1:0]  cmd_i,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  function automatic logic cmd_is_write(input logic [REG_W-1:0] c);
    return c[REG_W-1];
  endfunction

  function automatic logic [ADDR_W-1:0] cmd_addr(input logic [REG_W-1:0] c);
    return c[REG_W-2:DATA_W];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_o <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      write_o <= cmd_is_write(cmd_i);
      addr_o  <= cmd_addr(cmd_i);
      wdata_o <= cmd_i[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/pmic_chan_ctrl.sv
module pmic_chan_ctrl
  import pmic_chan_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_we_i,
  input  logic               clr_we_i,
  input  logic               clr_bit_i,
  input  logic               ack_i,
  input  logic               write_i,
  output logic [STATE_W-1:0] state_o,
  output logic               accept_o,
  output logic               capture_o,
  output logic               clr_hit_o
);
  ch_state_e state_q, state_d;

  assign accept_o  = (state_q == CH_IDLE) && cmd_we_i;
  assign capture_o = (state_q == CH_REQ) && ack_i && !write_i;
  assign clr_hit_o = (state_q == CH_WAIT_CLR) && clr_we_i && clr_bit_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      CH_IDLE:      if (accept_o) state_d = CH_REQ;
      CH_REQ:       if (ack_i) state_d = write_i ? CH_IDLE : CH_WAIT_DATA;
      CH_WAIT_DATA: state_d = CH_WAIT_CLR;
      CH_WAIT_CLR:  if (clr_hit_o) state_d = CH_IDLE;
      default:      state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CH_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pmic_rdata_hold.sv
module pmic_rdata_hold #(
  parameter int DATA_W = pmic_chan_pkg::PKG_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_o <= '0;
    else if (capture_i) rdata_o <= rdata_i;
  end
endmodule

// File: rtl/pmic_status_pack.sv
module pmic_status_pack
  import pmic_chan_pkg::*;
#(
  parameter int REG_W  = PKG_REG_W,
  parameter int DATA_W = PKG_DATA_W
) (
  input  logic [STATE_W-1:0] state_i,
  input  logic [DATA_W-1:0]  rdata_i,
  input  logic               link_idle_i,
  input  logic               init_done_i,
  output logic               pending_o,
  output logic [REG_W-1:0]   status_o
);
  localparam int PEND_B = DATA_W + STATE_W;
  localparam int SYNC_B = PEND_B + 1;
  localparam int INIT_B = PEND_B + 2;
  localparam int SYS_B  = PEND_B + 3;

  function automatic logic [REG_W-1:0] pack(
    input logic [STATE_W-1:0] st, input logic [DATA_W-1:0] rd,
    input logic pend, input logic link, input logic init);
    logic [REG_W-1:0] w;
    w = '0;
    w[DATA_W-1:0]        = rd;
    w[PEND_B-1:DATA_W]   = st;
    w[PEND_B]            = pend;
    w[SYNC_B]            = link;
    w[INIT_B]            = init;
    w[SYS_B]             = (st == CH_IDLE) && link;
    return w;
  endfunction

  assign pending_o = (state_i == CH_REQ);
  assign status_o  = pack(state_i, rdata_i, pending_o, link_idle_i, init_done_i);
endmodule

// File: rtl/pmic_chan_fsm.sv
module pmic_chan_fsm
  import pmic_chan_pkg::*;
#(
  parameter int REG_W  = PKG_REG_W,
  parameter int DATA_W = PKG_DATA_W,
  localparam int ADDR_W = REG_W - 1 - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  status_o,
  input  logic              init_done_i,
  input  logic              link_idle_i,
  output logic              be_valid_o,
  output logic              be_write_o,
  output logic [ADDR_W-1:0] be_addr_o,
  output logic [DATA_W-1:0] be_wdata_o,
  input  logic              be_ack_i,
  input  logic [DATA_W-1:0] be_rdata_i
);
  logic               cmd_we, clr_we;
  logic               cmd_accept, rd_capture, clr_hit, pending;
  logic [STATE_W-1:0] state;
  logic [DATA_W-1:0]  rdata_q;

  assign cmd_we = reg_we && !reg_sel;
  assign clr_we = reg_we && reg_sel;

  pmic_chan_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_we_i(cmd_we), .clr_we_i(clr_we),
    .clr_bit_i(reg_wdata[0]), .ack_i(be_ack_i), .write_i(be_write_o),
    .state_o(state), .accept_o(cmd_accept), .capture_o(rd_capture),
    .clr_hit_o(clr_hit)
  );

  pmic_cmd_hold #(.REG_W(REG_W), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load_i(cmd_accept), .cmd_i(reg_wdata),
    .write_o(be_write_o), .addr_o(be_addr_o), .wdata_o(be_wdata_o)
  );

  pmic_rdata_hold #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .capture_i(rd_capture),
    .rdata_i(be_rdata_i), .rdata_o(rdata_q)
  );

  pmic_status_pack #(.REG_W(REG_W), .DATA_W(DATA_W)) u_stat (
    .state_i(state), .rdata_i(rdata_q), .link_idle_i(link_idle_i),
    .init_done_i(init_done_i), .pending_o(pending), .status_o(status_o)
  );

  assign be_valid_o = pending;
endmodule

// File: rtl/pmic_chan_fsm_chk.sv
module pmic_chan_fsm_chk #(
  parameter int REG_W  = 32,
  parameter int DATA_W = 16,
  localparam int ADDR_W = REG_W - 1 - DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              reg_sel,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  status_o,
  input logic              be_valid_o,
  input logic              be_write_o,
  input logic [ADDR_W-1:0] be_addr_o,
  input logic              be_ack_i,
  input logic [DATA_W-1:0] be_rdata_i
);
  logic [2:0] st;
  logic       pend;
  assign st   = status_o[DATA_W+2:DATA_W];
  assign pend = status_o[DATA_W+3];

  AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && reg_we && !reg_sel) |=> (st == 3'd2 && pend)); // R1
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd0 && reg_we && !reg_sel) |=> ($stable(be_addr_o) && $stable(be_write_o))); // R2
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !be_ack_i) |=> pend); // R3
  AST_PEND_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && be_ack_i) |=> !pend); // R3
  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    be_valid_o == (st == 3'd2)); // R3
  AST_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2 && be_ack_i && be_write_o) |=> st == 3'd0); // R4
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2 && be_ack_i && !be_write_o) |=>
    (st == 3'd4 && status_o[DATA_W-1:0] == $past(be_rdata_i))); // R5
  AST_DATA_TO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd4 |=> st == 3'd6); // R5
  AST_CLR_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd6 && reg_we && reg_sel && reg_wdata[0]) |=> st == 3'd0); // R6
  AST_CLR_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && reg_we && reg_sel) |=> st == 3'd0); // R6
  AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 || st == 3'd2 || st == 3'd4 || st == 3'd6)); // R7
endmodule

bind pmic_chan_fsm pmic_chan_fsm_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .status_o(status_o), .be_valid_o(be_valid_o),
  .be_write_o(be_write_o), .be_addr_o(be_addr_o), .be_ack_i(be_ack_i),
  .be_rdata_i(be_rdata_i)
);

// File: tb/pmic_chan_fsm_bench.sv
module pmic_chan_fsm_bench;
  localparam int CLK_P = 10;
  localparam int S_IDLE = 0, S_REQ = 2, S_WDAT = 4, S_WCLR = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] status_o;
  logic        init_done_i = 1'b0, link_idle_i = 1'b0;
  logic        be_valid_o, be_write_o, be_ack_i = 1'b0;
  logic [14:0] be_addr_o;
  logic [15:0] be_wdata_o, be_rdata_i = '0;

  int n_chk = 0, n_bad = 0;
  logic [15:0] last_rd = '0;
  bit done = 0;

  pmic_chan_fsm u_pmic_chan_fsm (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .status_o(status_o), .init_done_i(init_done_i),
    .link_idle_i(link_idle_i), .be_valid_o(be_valid_o), .be_write_o(be_write_o),
    .be_addr_o(be_addr_o), .be_wdata_o(be_wdata_o), .be_ack_i(be_ack_i),
    .be_rdata_i(be_rdata_i)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] want(int st, logic [15:0] rd, bit pend);
    logic [31:0] w = 32'h0;
    w = w | {16'h0, rd};
    w = w | (32'(st) << 16);
    if (pend) w = w | 32'h0008_0000;
    if (link_idle_i) w = w | 32'h0010_0000;
    if (init_done_i) w = w | 32'h0020_0000;
    if (st == S_IDLE && link_idle_i) w = w | 32'h0040_0000;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic reg_write(bit sel, logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic txn(bit wr, logic [14:0] a, logic [15:0] d, int dly, logic [15:0] rd);
    reg_write(1'b0, {wr, a, d});
    chk("R1 status after accept", status_o, want(S_REQ, last_rd, 1));
    chk("R1 back-end fields", {be_valid_o, be_write_o, be_addr_o, be_wdata_o}, {1'b1, wr, a, d});
    for (int i = 0; i < dly; i++) begin
      if (i == 0) begin
        reg_write(1'b0, {~wr, ~a, ~d});
        chk("R2 busy command ignored", {status_o[18:16], be_write_o, be_addr_o, be_wdata_o},
            {3'(S_REQ), wr, a, d});
      end else if (i == 1) begin
        reg_write(1'b1, 32'h1);
        chk("R6 clear in REQ ignored", status_o, want(S_REQ, last_rd, 1));
      end else begin
        tick();
        chk("R3 pending until ack", {31'h0, be_valid_o}, 32'h1);
      end
    end
    be_ack_i = 1'b1; be_rdata_i = rd;
    tick();
    be_ack_i = 1'b0; be_rdata_i = $urandom;
    if (wr) begin
      chk("R4 write returns to idle", status_o, want(S_IDLE, last_rd, 0));
      chk("R3 valid drops after ack", {31'h0, be_valid_o}, 32'h0);
    end else begin
      chk("R5 wait-data with captured data", status_o, want(S_WDAT, rd, 0));
      tick();
      chk("R5 wait-valid-clear", status_o, want(S_WCLR, rd, 0));
      reg_write(1'b0, {1'b1, ~a, ~d});
      chk("R2 command in wait-clear ignored", {status_o[18:16], be_valid_o, be_addr_o},
          {3'(S_WCLR), 1'b0, a});
      reg_write(1'b1, 32'hFFFF_FFFE);
      chk("R6 clear with bit0 low ignored", status_o, want(S_WCLR, rd, 0));
      reg_write(1'b1, 32'h1);
      chk("R6 clear returns to idle", status_o, want(S_IDLE, rd, 0));
      last_rd = rd;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    chk("R8 reset status", status_o, 32'h0);
    chk("R8 reset valid", {31'h0, be_valid_o}, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R8 status after release", status_o, 32'h0);
    link_idle_i = 1'b1; init_done_i = 1'b1;
    #1;
    chk("R7 idle flags", status_o, 32'h0070_0000);
    reg_write(1'b1, 32'h1);
    chk("R6 clear in idle ignored", status_o, want(S_IDLE, 16'h0, 0));
    txn(1'b0, 15'h7FFF, 16'hFFFF, 0, 16'hA5C3);
    txn(1'b1, 15'h0000, 16'h0000, 0, 16'h1234);
    txn(1'b1, 15'h2AAA, 16'h55AA, 3, 16'h0);
    txn(1'b0, 15'h0001, 16'h0, 4, 16'h0000);
    for (int k = 0; k < 40; k++) begin
      link_idle_i = 1'($urandom);
      init_done_i = 1'($urandom);
      txn(1'($urandom), 15'($urandom), 16'($urandom), int'($urandom_range(0, 5)), 16'($urandom));
      chk("R7 idle status", status_o, want(S_IDLE, last_rd, 0));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule